// File: doc/BRIEF.md
# Dual-Word Codec Serial Port Sequencer

This block is the digital serial port of a codec that runs a two-word exchange with a host processor. Each conversion cycle starts when a new converter sample is offered on a parallel valid/ready input. The block then runs a primary transfer. It shifts the padded sample out on the receive line and, in the same bit times, shifts in a DAC word followed by two control bits from the transmit line. The captured DAC value is handed to the converter side on a parallel port with a one-cycle strobe.

When the two control bits are both one, a secondary transfer follows after a fixed gap. During this transfer the receive line relays a 16-bit word from an auxiliary serial input. The word arriving on the transmit line is presented as a register-programming word. Each phase has its own receive frame sync, and a shared transmit frame sync marks both phases. In byte mode every 16-bit word is split into two 8-bit halves, and each half gets its own frame sync.

One clock period is one shift clock. The block changes its outputs at the rising edge. The host samples the receive line mid-cycle and drives the transmit line so that it is stable at the rising edge that ends each bit.

Top module: `dw_codec_port`

## Requirements
- R1: After reset, all frame syncs, the receive line and both strobes are low, and `adc_ready` is high.
- R2: A cycle starts at a rising edge where `adc_valid` and `adc_ready` are both high. `adc_ready` stays low from the next cycle until the cycle ends. While `adc_valid` is held low, no frame starts and `adc_ready` stays high. This is the only back-pressure point, because the serial side cannot stall.
- R3: In word mode, a primary frame is one cycle with `fs_tx` and `fs_pri` high, followed by 16 data cycles with both syncs low.
- R4: In data cycle i of the primary word (i = 0..15), `rx_line` carries bit 15-i of {sample, 2'b00}. The 14-bit two's complement sample therefore goes MSB first, and the last two bits are zero.
- R5: `tx_line` is sampled at the rising edge that ends each data cycle, MSB first. In the cycle after the last primary bit, `dac_valid` is high for exactly one cycle and `dac_data` equals bits 15..2 of the received word.
- R6: If bits 1..0 of the primary transmit word are anything other than 2'b11, no secondary frame occurs. In that case `adc_ready` rises two cycles after the last primary data cycle.
- R7: If bits 1..0 equal 2'b11, the secondary sync cycle comes exactly 4 cycles after the last primary data cycle. No frame sync is high during those 4 cycles.
- R8: A secondary frame is one cycle with `fs_tx` and `fs_sec` high, followed by 16 data cycles. In each of these data cycles, `rx_line` carries the value `aux_in` had one cycle earlier.
- R9: In the cycle after the last secondary bit, `reg_valid` is high for one cycle and `reg_data` holds the full 16-bit secondary transmit word. `adc_ready` is high in that same cycle.
- R10: `fs_pri` is never high during a secondary frame or its gap, and `fs_sec` is never high during a primary frame.
- R11: In byte mode, every word is sent as two 8-bit halves, high half first, with the same bit order as in word mode. Each half is preceded by its own sync cycle, and the gap of R7 is counted from the last bit of the second half.
- R12: `byte_mode` is sampled only when a cycle starts. Changing it mid-cycle has no effect on that cycle's framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; one period per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects split 8-bit halves |
| adc_data | input | 14 | Converter sample, two's complement |
| adc_valid | input | 1 | Sample offered |
| adc_ready | output | 1 | Port idle, sample accepted |
| tx_line | input | 1 | Serial data from host |
| aux_in | input | 1 | Auxiliary serial data to relay |
| rx_line | output | 1 | Serial data to host |
| fs_tx | output | 1 | Transmit frame sync, both phases |
| fs_pri | output | 1 | Receive sync, primary phase |
| fs_sec | output | 1 | Receive sync, secondary phase |
| dac_data | output | 14 | Captured DAC word |
| dac_valid | output | 1 | One-cycle strobe for `dac_data` |
| reg_data | output | 16 | Captured register-programming word |
| reg_valid | output | 1 | One-cycle strobe for `reg_data` |

## Verification
The assertions assume that `adc_data` is stable at the edge where a cycle starts. They also assume that `tx_line` and `aux_in` are settled at every rising edge, and that `byte_mode` may move freely at other times. The stimulus changes every input only at falling edges. It drives each transmit bit during its own data cycle and each auxiliary bit one cycle ahead of its relay slot. It flips `byte_mode` right after every start, so the framing is checked against the latched mode and never against the pin. The sweep covers all four control-bit codes in both modes across several sample values, including the extreme positive and negative codes.

// File: rtl/dw_port_pkg.sv
package dw_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/dw_frame_seq.sv
module dw_frame_seq
  import dw_port_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_W   = 8,
  parameter int GAP_CLKS = 4,
  localparam int BIDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_mode,
  input  logic              sec_req,
  output logic              idle,
  output logic              sync,
  output logic              data,
  output logic              sec,
  output logic              last,
  output logic [BIDX_W-1:0] bidx
);
  localparam int GCNT_W = $clog2(GAP_CLKS + 1);
  localparam logic [BIDX_W-1:0] LAST_IDX  = BIDX_W'(WORD_W - 1);
  localparam logic [BIDX_W-1:0] HALF_IDX  = BIDX_W'(HALF_W - 1);
  localparam logic [GCNT_W-1:0] GAP_LAST  = GCNT_W'(GAP_CLKS - 1);

  seq_st_e             st_q;
  logic                sec_q;
  logic                bm_q;
  logic [BIDX_W-1:0]   bidx_q;
  logic [GCNT_W-1:0]   gcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sec_q  <= 1'b0;
      bm_q   <= 1'b0;
      bidx_q <= '0;
      gcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_SYNC;
          sec_q  <= 1'b0;
          bidx_q <= '0;
          bm_q   <= byte_mode;
        end
        ST_SYNC: st_q <= ST_DATA;
        ST_DATA: begin
          if (bidx_q == LAST_IDX) begin
            bidx_q <= '0;
            gcnt_q <= '0;
            st_q   <= sec_q ? ST_IDLE : ST_GAP;
          end else begin
            bidx_q <= bidx_q + 1'b1;
            if (bm_q && bidx_q == HALF_IDX) st_q <= ST_SYNC;
          end
        end
        default: begin
          if (gcnt_q == '0 && !sec_req) begin
            st_q <= ST_IDLE;
          end else if (gcnt_q == GAP_LAST) begin
            st_q  <= ST_SYNC;
            sec_q <= 1'b1;
          end else begin
            gcnt_q <= gcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign idle = (st_q == ST_IDLE);
  assign sync = (st_q == ST_SYNC);
  assign data = (st_q == ST_DATA);
  assign sec  = sec_q;
  assign last = (st_q == ST_DATA) && (bidx_q == LAST_IDX);
  assign bidx = bidx_q;

  // R3
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);

  // R11
  half_sync_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && bidx != '0) |-> (bm_q && bidx == BIDX_W'(HALF_W)));
endmodule

// File: rtl/dw_tx_deser.sv
module dw_tx_deser #(
  parameter int WORD_W = 16,
  parameter int ADC_W  = 14,
  localparam int PAD_W = WORD_W - ADC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_line,
  input  logic              data,
  input  logic              sec,
  input  logic              last,
  output logic [ADC_W-1:0]  dac_data,
  output logic              dac_valid,
  output logic [WORD_W-1:0] reg_data,
  output logic              reg_valid,
  output logic              sec_req
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] nxt;
  logic [ADC_W-1:0]  dac_q;
  logic [WORD_W-1:0] reg_q;
  logic              dac_v_q, reg_v_q, req_q;

  assign nxt = {sh_q[WORD_W-2:0], tx_line};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      dac_q   <= '0;
      reg_q   <= '0;
      dac_v_q <= 1'b0;
      reg_v_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      dac_v_q <= data && last && !sec;
      reg_v_q <= data && last && sec;
      if (data) sh_q <= nxt;
      if (data && last && !sec) begin
        dac_q <= nxt[WORD_W-1:PAD_W];
        req_q <= &nxt[PAD_W-1:0];
      end
      if (data && last && sec) reg_q <= nxt;
    end
  end

  assign dac_data  = dac_q;
  assign dac_valid = dac_v_q;
  assign reg_data  = reg_q;
  assign reg_valid = reg_v_q;
  assign sec_req   = req_q;

  // R5
  dac_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  // R9
  reg_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |=> !reg_valid);
endmodule

// File: rtl/dw_rx_ser.sv
module dw_rx_ser #(
  parameter int WORD_W  = 16,
  parameter int ADC_W   = 14,
  localparam int PAD_W  = WORD_W - ADC_W,
  localparam int BIDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADC_W-1:0]  adc_data,
  input  logic              aux_in,
  input  logic              data,
  input  logic              sec,
  input  logic [BIDX_W-1:0] bidx,
  output logic              rx_line
);
  localparam logic [BIDX_W-1:0] TOP_IDX = BIDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] word_q;
  logic              aux_q;
  logic [BIDX_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      aux_q  <= 1'b0;
    end else begin
      aux_q <= aux_in;
      if (load) word_q <= {adc_data, PAD_W'(0)};
    end
  end

  assign sel     = TOP_IDX - bidx;
  assign rx_line = data && (sec ? aux_q : word_q[sel]);

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data && !sec && bidx >= BIDX_W'(ADC_W)) |-> !rx_line);

  // R8
  aux_relay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data && sec) |-> (rx_line == $past(aux_in)));
endmodule

// File: rtl/dw_codec_port.sv
module dw_codec_port #(
  parameter int WORD_W   = 16,
  parameter int ADC_W    = 14,
  parameter int HALF_W   = 8,
  parameter int GAP_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic [ADC_W-1:0]  adc_data,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic              tx_line,
  input  logic              aux_in,
  output logic              rx_line,
  output logic              fs_tx,
  output logic              fs_pri,
  output logic              fs_sec,
  output logic [ADC_W-1:0]  dac_data,
  output logic              dac_valid,
  output logic [WORD_W-1:0] reg_data,
  output logic              reg_valid
);
  localparam int BIDX_W = $clog2(WORD_W);
  localparam int GC_W   = $clog2(GAP_CLKS + 2);

  logic              idle, sync, data, sec, last, sec_req, start;
  logic [BIDX_W-1:0] bidx;

  assign start = adc_valid && idle;

  dw_frame_seq #(.WORD_W(WORD_W), .HALF_W(HALF_W), .GAP_CLKS(GAP_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
    .sec_req(sec_req), .idle(idle), .sync(sync), .data(data), .sec(sec),
    .last(last), .bidx(bidx)
  );

  dw_tx_deser #(.WORD_W(WORD_W), .ADC_W(ADC_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .data(data), .sec(sec),
    .last(last), .dac_data(dac_data), .dac_valid(dac_valid),
    .reg_data(reg_data), .reg_valid(reg_valid), .sec_req(sec_req)
  );

  dw_rx_ser #(.WORD_W(WORD_W), .ADC_W(ADC_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(start), .adc_data(adc_data),
    .aux_in(aux_in), .data(data), .sec(sec), .bidx(bidx), .rx_line(rx_line)
  );

  assign adc_ready = idle;
  assign fs_tx     = sync;
  assign fs_pri    = sync && !sec;
  assign fs_sec    = sync && sec;

  // cycles since the last primary data bit, saturating
  logic [GC_W-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) gap_cnt <= GC_W'(GAP_CLKS + 1);
    else if (data && last && !sec) gap_cnt <= '0;
    else if (gap_cnt != GC_W'(GAP_CLKS + 1)) gap_cnt <= gap_cnt + 1'b1;
  end

  // R7
  sec_gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_sec && bidx == '0) |-> (gap_cnt == GC_W'(GAP_CLKS)));

  // R6
  sec_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_sec |-> sec_req);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tx |-> !adc_ready);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_ready) |-> $past(adc_valid));

  // R10
  fs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fs_pri, fs_sec}));
endmodule

// File: tb/dw_codec_port_bench.sv
module dw_codec_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic [13:0] adc_data = '0;
  logic        adc_valid = 1'b0;
  logic        adc_ready;
  logic        tx_line = 1'b0;
  logic        aux_in = 1'b0;
  logic        rx_line, fs_tx, fs_pri, fs_sec;
  logic [13:0] dac_data;
  logic        dac_valid;
  logic [15:0] reg_data;
  logic        reg_valid;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dw_codec_port u_dw_codec_port (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .adc_data(adc_data),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .tx_line(tx_line),
    .aux_in(aux_in), .rx_line(rx_line), .fs_tx(fs_tx), .fs_pri(fs_pri),
    .fs_sec(fs_sec), .dac_data(dac_data), .dac_valid(dac_valid),
    .reg_data(reg_data), .reg_valid(reg_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one word: sync cycle(s) plus 16 data cycles; entered just before the sync negedge
  task automatic xfer(input bit sec, input logic [15:0] txw, input logic [15:0] rxw, input bit bm);
    for (int i = 0; i < 16; i++) begin
      if (i == 0 || (bm && i == 8)) begin
        @(negedge clk);
        chk(sec ? "R8 fs_tx" : "R3 fs_tx", fs_tx, 1);
        chk("R10 fs_pri", fs_pri, !sec);
        chk("R10 fs_sec", fs_sec, sec);
        chk("R2 ready busy", adc_ready, 0);
        if (i == 0 && !sec) begin
          adc_valid = 1'b0;
          byte_mode = !bm;  // R12: pin flipped mid-cycle
        end
        if (i == 0 && sec) aux_in = rxw[15];
      end
      @(negedge clk);
      chk(bm ? "R11 no sync" : "R3 no sync", fs_tx, 0);
      chk(sec ? "R8 rx relay" : "R4 rx data", rx_line, rxw[15-i]);
      tx_line = txw[15-i];
      if (sec && i < 15) aux_in = rxw[14-i];
    end
  endtask

  task automatic run_cycle(input logic [13:0] adc, input logic [15:0] txp,
                           input logic [15:0] aux, input logic [15:0] txs, input bit bm);
    @(negedge clk);
    chk("R2 ready idle", adc_ready, 1);
    byte_mode = bm;
    adc_data  = adc;
    adc_valid = 1'b1;
    xfer(1'b0, txp, {adc, 2'b00}, bm);
    @(negedge clk);
    chk("R5 dac_valid", dac_valid, 1);
    chk("R5 dac_data", dac_data, txp[15:2]);
    chk("R6 ready after primary", adc_ready, 0);
    if (txp[1:0] != 2'b11) begin
      @(negedge clk);
      chk("R6 ready back", adc_ready, 1);
      chk("R5 dac pulse", dac_valid, 0);
      chk("R6 no sec sync", fs_sec, 0);
    end else begin
      for (int g = 0; g < 3; g++) begin
        @(negedge clk);
        chk("R7 gap quiet", {fs_tx, fs_pri, fs_sec}, 0);
        chk("R7 gap busy", adc_ready, 0);
      end
      xfer(1'b1, txs, aux, bm);
      @(negedge clk);
      chk("R9 reg_valid", reg_valid, 1);
      chk("R9 reg_data", reg_data, txs);
      chk("R9 ready", adc_ready, 1);
      @(negedge clk);
      chk("R9 reg pulse", reg_valid, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 fs_tx", fs_tx, 0);
    chk("R1 fs_pri", fs_pri, 0);
    chk("R1 fs_sec", fs_sec, 0);
    chk("R1 rx", rx_line, 0);
    chk("R1 strobes", {dac_valid, reg_valid}, 0);
    chk("R1 ready", adc_ready, 1);
    rst_n = 1'b1;
    // R2 stall: nothing happens without adc_valid
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      chk("R2 stall ready", adc_ready, 1);
      chk("R2 stall fs", fs_tx, 0);
    end
    for (int k = 0; k < 6; k++) begin
      for (int bm = 0; bm < 2; bm++) begin
        for (int code = 0; code < 4; code++) begin
          logic [13:0] adc;
          logic [13:0] dac;
          logic [15:0] aux;
          case (k)
            0: adc = 14'h1FFF;
            1: adc = 14'h2000;
            2: adc = 14'h3FFF;
            default: adc = 14'((k * 2731 + code * 97 + 5) & 16'h3FFF);
          endcase
          dac = 14'((k * 1237 + code * 91 + bm * 7 + 3) & 16'h3FFF);
          aux = 16'((k * 40503 + code * 257 + bm * 4099 + 11) & 32'hFFFF);
          run_cycle(adc, {dac, 2'(code)}, aux, aux ^ 16'h5A3C, bm[0]);
        end
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule